// File: doc/BRIEF.md
# Dual-Channel Timer Capture Unit

A 16-bit timer with two input-capture channels. Each channel watches one input pin. On a qualifying edge it copies the current timer value into its own 16-bit capture register and raises that channel's interrupt flag. A mode bit decides what the first 16-bit register does. When the bit is set, the register is capture channel 0 and the timer wraps only at FFFFh. When the bit is clear, the register holds a period limit for the timer and channel 0 never captures.

A capture value that has not yet been read is never replaced. An event that arrives while the register holds an unread value is recorded in a hidden overflow bit. That bit becomes visible in the status register only after software has read both bytes of that capture register, in either order. All registers are reached through a byte-wide bus: a write strobe, a read strobe, a 4-bit address and a combinational read-data path. A read has its side effects on the clock edge where its strobe is sampled.

Top module: `dual_capture_timer`

## Requirements
- R1: After reset, every register address 0 to 8 reads 00h and `irq` is 000.
- R2: Address 0 (CTRL) is read/write. Bit 0 is run and bit 1 is source select. With run set and source select at 0, the timer increments on each clock where `tick_en` is high. With run clear, the timer holds its value.
- R3: With run set and source select at 1, the timer increments once for each rising edge of `ext_clk`, and `tick_en` is ignored. The pin passes through a two-flop synchronizer and edge detection first.
- R4: CTRL bit 2 set selects dual-capture mode. In this mode the timer goes from FFFFh to 0000h and sets status bit 0. Address 1 (STAT) holds this flag, and it stays set until software writes STAT with bit 0 set (write-one-to-clear).
- R5: CTRL bit 2 clear selects period mode. Addresses 5 (low byte) and 6 (high byte) are then a writable period value. The timer counts from 0 up to the period, then returns to 0 and sets STAT bit 0. Channel 0 ignores its pin.
- R6: Channel c (0 or 1) takes its select field from CTRL bits 5:4 (c=0) or 7:6 (c=1). Code 00 captures on every falling edge and code 01 on every rising edge. Channel 0's capture register is at addresses 5 and 6 and channel 1's at 7 and 8, low byte first. The captured value is the timer value at the clock where the synchronized edge is detected.
- R7: Select code 10 captures on every 4th rising edge and code 11 on every 16th. The edge counter restarts from zero whenever a CTRL write changes that channel's select field.
- R8: Each capture event sets STAT bit 1+c, and writing 1 to that bit clears it. Address 2 (IEN) bits 0, 1 and 2 enable the timer flag, the channel 0 flag and the channel 1 flag. `irq` bit n is high exactly while flag n and enable n are both set.
- R9: A capture register is unread from the moment it is loaded until both of its bytes have been read. An event that arrives while it is unread still sets the channel flag, leaves the register unchanged and sets a hidden overflow bit.
- R10: When the second of the two byte reads of a capture register completes, in either order, the hidden overflow bit is copied to STAT bit 4+c and the hidden bit is cleared.
- R11: The timer bytes at addresses 3 (low) and 4 (high) are writable. A write takes the place of that cycle's increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Internal count enable |
| ext_clk | input | 1 | External count pin, asynchronous |
| cap_in | input | 2 | Capture pins, bit c for channel c, asynchronous |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe, triggers read side effects |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq | output | 3 | Enabled flags: timer, channel 0, channel 1 |

## Verification
The timer is driven with a stopped timer, with bursts of internal ticks and with a toggled external pin. This separates the clock sources and shows whether the enable really holds the count. Capture is run with a stopped timer at known values, so that the falling and rising codes and the lost-event path give exact register contents. Separate patterns cover a second event before a read, a high-then-low read order, and a re-capture after the register is freed. These tell a true overwrite apart from a correctly blocked event, and an early overflow report apart from one that appears only after both bytes are read. Pulse trains of 3, 4, 15 and 16 edges, with and without a select change partway through, show whether the divider is right and whether it restarts. A long random run with mixed reads and writes is compared every clock against a behavioural model.

// File: rtl/dual_capture_timer.sv
module dual_capture_timer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       ext_clk,
  input  logic [1:0] cap_in,
  input  logic [3:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic [2:0] irq
);
  localparam logic [3:0] A_CTRL = 4'd0, A_STAT = 4'd1, A_IEN = 4'd2;
  localparam logic [3:0] A_TLO = 4'd3, A_THI = 4'd4, A_C0L = 4'd5, A_C0H = 4'd6;
  localparam logic [3:0] A_C1L = 4'd7, A_C1H = 4'd8;

  logic [7:0]  ctrl;
  logic [2:0]  ien;
  logic [15:0] tmr;
  logic        tflag;
  logic [15:0] cap [2];
  logic [3:0]  psc [2];
  logic [1:0]  cflag, unread, rdl, rdh, movf, vovf;
  logic [2:0]  s1, s2, s3;
  logic [1:0]  ev, act, lo_hit, hi_hit, comp, pdone, sel_chg;

  wire run     = ctrl[0];
  wire src_ext = ctrl[1];
  wire dual    = ctrl[2];

  wire [2:0] rise = s2 & ~s3;
  wire [1:0] fall = s3[1:0] & ~s2[1:0];

  wire wr_ctrl = bus_wr && bus_addr == A_CTRL;
  wire wr_stat = bus_wr && bus_addr == A_STAT;
  wire wr_ien  = bus_wr && bus_addr == A_IEN;
  wire wr_tlo  = bus_wr && bus_addr == A_TLO;
  wire wr_thi  = bus_wr && bus_addr == A_THI;
  wire tmr_wr  = wr_tlo || wr_thi;

  wire [15:0] top = dual ? 16'hFFFF : cap[0];
  wire inc  = run && (src_ext ? rise[2] : tick_en);
  wire wrap = inc && !tmr_wr && tmr == top;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= {ext_clk, cap_in};
      s2 <= s1;
      s3 <= s2;
    end

  always_comb
    for (int c = 0; c < 2; c++) begin
      act[c]   = (c == 1) || dual;
      pdone[c] = psc[c] == (ctrl[4+2*c] ? 4'd15 : 4'd3);
      case (ctrl[4+2*c +: 2])
        2'b00:   ev[c] = fall[c];
        2'b01:   ev[c] = rise[c];
        default: ev[c] = rise[c] && pdone[c];
      endcase
      ev[c]      = ev[c] && act[c];
      sel_chg[c] = wr_ctrl && bus_wdata[4+2*c +: 2] != ctrl[4+2*c +: 2];
      lo_hit[c]  = bus_rd && act[c] && bus_addr == 4'(5 + 2*c);
      hi_hit[c]  = bus_rd && act[c] && bus_addr == 4'(6 + 2*c);
      comp[c]    = (rdl[c] | lo_hit[c]) & (rdh[c] | hi_hit[c]) & (lo_hit[c] | hi_hit[c]);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl <= '0; ien <= '0; tmr <= '0; tflag <= 1'b0;
      cflag <= '0; unread <= '0; rdl <= '0; rdh <= '0; movf <= '0; vovf <= '0;
      for (int c = 0; c < 2; c++) begin
        cap[c] <= '0;
        psc[c] <= '0;
      end
    end else begin
      if (wr_ctrl) ctrl <= bus_wdata;
      if (wr_ien)  ien  <= bus_wdata[2:0];

      if (wr_tlo)      tmr[7:0]  <= bus_wdata;
      else if (wr_thi) tmr[15:8] <= bus_wdata;
      else if (inc)    tmr <= (tmr == top) ? 16'h0 : tmr + 16'h1;

      if (wrap)                         tflag <= 1'b1;
      else if (wr_stat && bus_wdata[0]) tflag <= 1'b0;

      for (int c = 0; c < 2; c++) begin
        if (sel_chg[c])                       psc[c] <= '0;
        else if (rise[c] && ctrl[5+2*c])      psc[c] <= pdone[c] ? 4'd0 : psc[c] + 4'd1;

        if (comp[c]) begin
          vovf[c] <= movf[c];
          movf[c] <= 1'b0;
          rdl[c] <= 1'b0; rdh[c] <= 1'b0;
          unread[c] <= 1'b0;
        end else begin
          if (lo_hit[c]) rdl[c] <= 1'b1;
          if (hi_hit[c]) rdh[c] <= 1'b1;
        end

        if (ev[c]) begin
          cflag[c] <= 1'b1;
          if (unread[c]) movf[c] <= 1'b1;
          else begin
            cap[c] <= tmr;
            unread[c] <= 1'b1;
            rdl[c] <= 1'b0; rdh[c] <= 1'b0;
          end
        end else if (wr_stat && bus_wdata[1+c]) cflag[c] <= 1'b0;

        if (c == 0 && !dual && bus_wr && bus_addr == A_C0L) cap[c][7:0]  <= bus_wdata;
        if (c == 0 && !dual && bus_wr && bus_addr == A_C0H) cap[c][15:8] <= bus_wdata;
      end
    end

  always_comb
    case (bus_addr)
      A_CTRL:  bus_rdata = ctrl;
      A_STAT:  bus_rdata = {2'b00, vovf, 1'b0, cflag, tflag};
      A_IEN:   bus_rdata = {5'b0, ien};
      A_TLO:   bus_rdata = tmr[7:0];
      A_THI:   bus_rdata = tmr[15:8];
      A_C0L:   bus_rdata = cap[0][7:0];
      A_C0H:   bus_rdata = cap[0][15:8];
      A_C1L:   bus_rdata = cap[1][7:0];
      A_C1H:   bus_rdata = cap[1][15:8];
      default: bus_rdata = 8'h00;
    endcase

  assign irq = {cflag, tflag} & ien;

  // R9
  cap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unread[1] |=> $stable(cap[1]));

  // R9
  hidden_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(movf[0]) |-> $past(unread[0]));

  // R4
  tflag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tflag && !(wr_stat && bus_wdata[0]) |=> tflag);

  // R4
  full_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dual && inc && !tmr_wr && tmr == 16'hFFFF |=> tmr == 16'h0000 && tflag);

  // R2
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !tmr_wr |=> $stable(tmr));

  // R10
  vis_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vovf) |-> $past(bus_rd));
endmodule

// File: tb/dual_capture_timer_bench.sv
module dual_capture_timer_bench;
  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, ext_clk = 1'b0;
  logic [1:0] cap_in = 2'b00;
  logic [3:0] bus_addr = 4'd0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic [2:0] irq;

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dual_capture_timer u_dual_capture_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ext_clk(ext_clk), .cap_in(cap_in),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq));

  // behavioural reference model
  int m_ctrl, m_ien, m_tmr, m_tf;
  int m_cap[2], m_psc[2], m_cf[2], m_unr[2], m_rdl[2], m_rdh[2], m_mo[2], m_vo[2];
  int m_s1[3], m_s2[3], m_s3[3];
  int rx[3], fx[3], pin[3];
  int dual, inc, twr, top, wrap, old_tmr, sel, nsel, lim, e, act, lo, hi, done, oldu;

  function automatic int m_rd(int a);
    case (a)
      0: return m_ctrl;
      1: return m_tf | (m_cf[0] << 1) | (m_cf[1] << 2) | (m_vo[0] << 4) | (m_vo[1] << 5);
      2: return m_ien;
      3: return m_tmr % 256;
      4: return m_tmr / 256;
      5: return m_cap[0] % 256;
      6: return m_cap[0] / 256;
      7: return m_cap[1] % 256;
      8: return m_cap[1] / 256;
      default: return 0;
    endcase
  endfunction

  function automatic int m_irq();
    return (m_tf & m_ien) | ((m_cf[0] << 1) & m_ien) | ((m_cf[1] << 2) & m_ien);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_ien = 0; m_tmr = 0; m_tf = 0;
      for (int i = 0; i < 3; i++) begin m_s1[i] = 0; m_s2[i] = 0; m_s3[i] = 0; end
      for (int c = 0; c < 2; c++) begin
        m_cap[c] = 0; m_psc[c] = 0; m_cf[c] = 0; m_unr[c] = 0;
        m_rdl[c] = 0; m_rdh[c] = 0; m_mo[c] = 0; m_vo[c] = 0;
      end
    end else begin
      for (int i = 0; i < 3; i++) begin
        rx[i] = (m_s2[i] == 1 && m_s3[i] == 0) ? 1 : 0;
        fx[i] = (m_s2[i] == 0 && m_s3[i] == 1) ? 1 : 0;
      end
      dual = (m_ctrl / 4) % 2;
      inc = (m_ctrl % 2 == 1) && (((m_ctrl / 2) % 2 == 1) ? rx[2] == 1 : tick_en == 1);
      twr = bus_wr && (bus_addr == 3 || bus_addr == 4);
      top = dual ? 65535 : m_cap[0];
      wrap = inc && !twr && m_tmr == top;
      old_tmr = m_tmr;
      for (int c = 0; c < 2; c++) begin
        sel = (m_ctrl >> (4 + 2*c)) % 4;
        act = (c == 1) || dual;
        lim = (sel == 3) ? 16 : 4;
        if (sel == 0) e = fx[c];
        else if (sel == 1) e = rx[c];
        else e = (rx[c] == 1 && m_psc[c] == lim - 1) ? 1 : 0;
        e = e && act;
        nsel = (bus_wr && bus_addr == 0) ? (int'(bus_wdata) >> (4 + 2*c)) % 4 : sel;
        if (nsel != sel) m_psc[c] = 0;
        else if (rx[c] == 1 && sel >= 2) m_psc[c] = (m_psc[c] == lim - 1) ? 0 : m_psc[c] + 1;
        lo = bus_rd && act && bus_addr == 5 + 2*c;
        hi = bus_rd && act && bus_addr == 6 + 2*c;
        done = (m_rdl[c] || lo) && (m_rdh[c] || hi) && (lo || hi);
        oldu = m_unr[c];
        if (done) begin
          m_vo[c] = m_mo[c]; m_mo[c] = 0; m_rdl[c] = 0; m_rdh[c] = 0; m_unr[c] = 0;
        end else begin
          if (lo) m_rdl[c] = 1;
          if (hi) m_rdh[c] = 1;
        end
        if (e) begin
          m_cf[c] = 1;
          if (oldu) m_mo[c] = 1;
          else begin m_cap[c] = old_tmr; m_unr[c] = 1; m_rdl[c] = 0; m_rdh[c] = 0; end
        end else if (bus_wr && bus_addr == 1 && bus_wdata[1+c]) m_cf[c] = 0;
      end
      if (!dual && bus_wr && bus_addr == 5) m_cap[0] = (m_cap[0] / 256) * 256 + int'(bus_wdata);
      if (!dual && bus_wr && bus_addr == 6) m_cap[0] = m_cap[0] % 256 + int'(bus_wdata) * 256;
      if (bus_wr && bus_addr == 3) m_tmr = (m_tmr / 256) * 256 + int'(bus_wdata);
      else if (bus_wr && bus_addr == 4) m_tmr = m_tmr % 256 + int'(bus_wdata) * 256;
      else if (inc) m_tmr = (m_tmr == top) ? 0 : m_tmr + 1;
      if (wrap) m_tf = 1;
      else if (bus_wr && bus_addr == 1 && bus_wdata[0]) m_tf = 0;
      if (bus_wr && bus_addr == 0) m_ctrl = int'(bus_wdata);
      if (bus_wr && bus_addr == 2) m_ien = int'(bus_wdata) % 8;
      pin[0] = int'(cap_in[0]); pin[1] = int'(cap_in[1]); pin[2] = int'(ext_clk);
      for (int i = 0; i < 3; i++) begin m_s3[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = pin[i]; end
    end
  end

  always @(negedge clk)
    if (rst_n && !finished) begin
      n_cmp++;
      if (bus_rdata !== 8'(m_rd(int'(bus_addr))) || irq !== 3'(m_irq())) begin
        n_bad++;
        $display("FAIL model compare (R2 R6 R8 R9): rdata=%h irq=%b expected %h %b",
                 bus_rdata, irq, 8'(m_rd(int'(bus_addr))), 3'(m_irq()));
      end
    end

  task automatic check(string req, int act_v, int exp_v);
    n_cmp++;
    if (act_v != exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act_v, exp_v);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); #1;
    bus_addr = 4'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
    @(negedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk); #1;
    bus_addr = 4'(a); bus_rd = 1'b1;
    #2 d = int'(bus_rdata);
    @(negedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int ch);
    @(negedge clk); #1 cap_in[ch] = 1'b1;
    idle(3); #1 cap_in[ch] = 1'b0;
    idle(3);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired (R1)");
    summary();
  end

  initial begin
    int d;
    idle(3); #1 rst_n = 1'b1;
    idle(2);
    // R1 reset values
    for (int a = 0; a < 9; a++) begin rd(a, d); check("R1 reset register", d, 0); end
    check("R1 reset irq", int'(irq), 0);

    // R11 timer write with the timer stopped
    wr(3, 'h34); wr(4, 'h12);
    rd(3, d); check("R11 timer low", d, 'h34);
    rd(4, d); check("R11 timer high", d, 'h12);

    // R4 wrap at FFFFh in dual mode, flag held until cleared
    tick_en = 1'b1;
    wr(0, 'h04); wr(3, 'hFE); wr(4, 'hFF); wr(0, 'h05);
    idle(4);
    rd(1, d); check("R4 wrap flag set", d & 1, 1);
    idle(5);
    rd(1, d); check("R4 wrap flag held", d & 1, 1);
    wr(1, 1);
    rd(1, d); check("R4 wrap flag cleared", d & 1, 0);

    // R2 internal ticks and stop
    wr(0, 'h04); tick_en = 1'b0; wr(3, 0); wr(4, 0); wr(0, 'h05);
    idle(10);
    rd(3, d); check("R2 no tick no count", d, 0);
    @(negedge clk); #1 tick_en = 1'b1;
    repeat (7) @(negedge clk);
    #1 tick_en = 1'b0;
    rd(3, d); check("R2 seven ticks", d, 7);
    wr(0, 'h04); tick_en = 1'b1; idle(5);
    rd(3, d); check("R2 stopped timer holds", d, 7);

    // R3 external pin source, tick_en ignored
    wr(3, 0); wr(0, 'h07);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); #1 ext_clk = 1'b1; idle(2); #1 ext_clk = 1'b0; idle(2);
    end
    idle(4); wr(0, 'h04);
    rd(3, d); check("R3 external edges counted", d, 5);

    // R6 falling-edge capture on channel 1 with a stopped timer
    tick_en = 1'b0;
    wr(3, 'hBC); wr(4, 'h0A);
    pulse(1);
    rd(7, d); check("R6 capture low", d, 'hBC);
    rd(8, d); check("R6 capture high", d, 'h0A);

    // R9 R10 lost event, hidden then visible overflow
    wr(3, 'h11); wr(4, 'h01); pulse(1);
    wr(3, 'h22); wr(4, 'h02); pulse(1);
    rd(1, d); check("R9 flag on lost event", (d >> 2) & 1, 1);
    check("R10 overflow hidden before reads", (d >> 5) & 1, 0);
    rd(8, d); check("R9 unread value kept high", d, 'h01);
    rd(1, d); check("R10 hidden after one byte", (d >> 5) & 1, 0);
    rd(7, d); check("R9 unread value kept low", d, 'h11);
    rd(1, d); check("R10 overflow visible", (d >> 5) & 1, 1);
    pulse(1);
    rd(7, d); check("R9 capture after free", d, 'h22);
    rd(8, d); check("R9 capture after free high", d, 'h02);
    rd(1, d); check("R10 overflow cleared next read pair", (d >> 5) & 1, 0);

    // R8 flag masking
    wr(1, 7); wr(2, 4); pulse(1);
    check("R8 irq channel 1", int'(irq), 4);
    wr(2, 0);
    check("R8 irq masked", int'(irq), 0);
    rd(7, d); rd(8, d);

    // R7 divide by 4 and 16, restart on select change
    wr(1, 7); wr(0, 'h84);
    for (int k = 0; k < 3; k++) pulse(1);
    rd(1, d); check("R7 no event after 3", (d >> 2) & 1, 0);
    pulse(1);
    rd(1, d); check("R7 event on 4th", (d >> 2) & 1, 1);
    wr(1, 7);
    pulse(1); pulse(1);
    wr(0, 'hC4); wr(0, 'h84);
    for (int k = 0; k < 3; k++) pulse(1);
    rd(1, d); check("R7 counter restarted", (d >> 2) & 1, 0);
    pulse(1);
    rd(1, d); check("R7 event after restart", (d >> 2) & 1, 1);
    wr(0, 'hC4); wr(1, 7);
    for (int k = 0; k < 15; k++) pulse(1);
    rd(1, d); check("R7 no event after 15", (d >> 2) & 1, 0);
    pulse(1);
    rd(1, d); check("R7 event on 16th", (d >> 2) & 1, 1);

    // R5 period mode, channel 0 inactive
    wr(0, 'h10); wr(5, 5); wr(6, 0); wr(3, 0); wr(4, 0); wr(1, 7);
    tick_en = 1'b1; wr(0, 'h11);
    idle(20); pulse(0);
    rd(1, d); check("R5 period wrap flag", d & 1, 1);
    check("R5 channel 0 ignored", (d >> 1) & 1, 0);
    rd(3, d); check("R5 timer within period", (d <= 5) ? 1 : 0, 1);
    rd(5, d); check("R5 period readback", d, 5);

    // random run against the model
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk); #1;
      tick_en = 1'($urandom % 2);
      if ($urandom % 4 == 0) ext_clk = ~ext_clk;
      if ($urandom % 6 == 0) cap_in[0] = ~cap_in[0];
      if ($urandom % 5 == 0) cap_in[1] = ~cap_in[1];
      bus_rd = 1'b0; bus_wr = 1'b0;
      case ($urandom % 20)
        0: begin bus_wr = 1'b1; bus_addr = 4'($urandom % 9); bus_wdata = 8'($urandom); end
        1, 2, 3, 4, 5, 6: begin bus_rd = 1'b1; bus_addr = 4'($urandom % 9); end
        default: bus_addr = 4'($urandom % 9);
      endcase
    end
    @(negedge clk); #1 bus_rd = 1'b0; bus_wr = 1'b0;
    idle(4);
    summary();
  end
endmodule